// File: doc/BRIEF.md
# Operate Group Accumulator-Link Unit

This block applies one operate-type micro-operation per cycle to a 12-bit accumulator and its 1-bit link. It is purely combinational: the surrounding datapath presents the current accumulator, link and front-panel switch value together with a one-hot request vector. The block returns the values that accumulator and link should take next, and a program-counter increment request derived from a supplied skip condition.

The operations are clearing the accumulator or loading it with all ones, bitwise complement, two's-complement negate, increment, and rotation of the 13-bit ring formed by the link (most significant) and the accumulator, one or two places in either direction. It also clears, sets or inverts the link, and ORs the switch value into the accumulator. Decoding instructions into requests and ordering combined micro-operations are left to the caller. Internally a priority picker turns the request vector into an operation code. Accumulator arithmetic, link logic and four ring rotators then run in parallel, and the top selects among them.

Top module: `opr_acc_link`

## Requirements
- R1: With no request bit set, `ac_next` equals `ac_cur` and `link_next` equals `link_cur`.
- R2: Request bit 0 gives `ac_next` = 0; request bit 1 gives `ac_next` = all ones; the link is unchanged for both.
- R3: Request bit 2 gives `ac_next` = bitwise inverse of `ac_cur`; request bit 3 gives the inverse plus one modulo 4096; the link is unchanged for both.
- R4: Request bit 4 gives `ac_next` = `ac_cur` + 1 modulo 4096 (7777 octal wraps to 0), and the link is unchanged.
- R5: Request bits 5 and 6 rotate the 13-bit value {link, AC} left by one and by two places into {`link_next`, `ac_next`}.
- R6: Request bits 7 and 8 rotate the 13-bit value {link, AC} right by one and by two places into {`link_next`, `ac_next`}.
- R7: Request bits 9, 10 and 11 set the link to 0, to 1, and to its inverse, and leave the accumulator unchanged.
- R8: Request bit 12 gives `ac_next` = `ac_cur` OR `sw_val`, and the link is unchanged.
- R9: `pc_inc` equals `skip_req` AND `skip_cond`, whatever operation is requested.
- R10: When more than one request bit is set, only the lowest-numbered set bit takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ac_cur | input | 12 | Present accumulator value |
| link_cur | input | 1 | Present link bit |
| sw_val | input | 12 | Switch register value |
| op_req | input | 13 | Operation request vector, bit positions as in R2 to R8 |
| skip_req | input | 1 | A skip is being evaluated this cycle |
| skip_cond | input | 1 | Result of the skip condition |
| ac_next | output | 12 | Accumulator value after the operation |
| link_next | output | 1 | Link value after the operation |
| pc_inc | output | 1 | Request to advance the program counter |

## Verification
The bench targets the wrap points: incrementing 7777 octal and negating 0 and 4000 octal. A design that carried into the link or saturated would return a wrong accumulator or a changed link. Two-place rotates are driven with a lone bit at each end of the ring, so that a rotator treating the accumulator as a 12-bit ring, or dropping the link, shows the bit in the wrong place. Request vectors with several bits set confirm the lowest bit wins, and skip cases with the condition false confirm `pc_inc` stays low.

// File: rtl/opr_pkg.sv
package opr_pkg;
    localparam int NREQ = 13;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLR,
        OP_ONES,
        OP_CMP,
        OP_NEG,
        OP_INC,
        OP_RL1,
        OP_RL2,
        OP_RR1,
        OP_RR2,
        OP_LCLR,
        OP_LSET,
        OP_LCMP,
        OP_OSR
    } op_e;

    function automatic logic is_rotate(input op_e op);
        return (op == OP_RL1) || (op == OP_RL2) || (op == OP_RR1) || (op == OP_RR2);
    endfunction
endpackage

// File: rtl/opr_pick.sv
module opr_pick
    import opr_pkg::*;
(
    input  logic [NREQ-1:0] req,
    output op_e             op
);
    always_comb begin
        op = OP_NONE;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) op = op_e'(4'(i + 1));
        end
    end

    always_comb begin
        if (req == '0)
            AST_PICK_IDLE: assert (op == OP_NONE); // R1
        if (req[0])
            AST_PICK_LOWEST: assert (op == OP_CLR); // R10
    end
endmodule

// File: rtl/opr_acc_math.sv
module opr_acc_math
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input  op_e          op,
    input  logic [W-1:0] ac_in,
    input  logic [W-1:0] sw_in,
    output logic [W-1:0] ac_out
);
    logic [W-1:0] inv;

    assign inv = ~ac_in;

    always_comb begin
        unique case (op)
            OP_CLR:  ac_out = '0;
            OP_ONES: ac_out = '1;
            OP_CMP:  ac_out = inv;
            OP_NEG:  ac_out = inv + W'(1);
            OP_INC:  ac_out = ac_in + W'(1);
            OP_OSR:  ac_out = ac_in | sw_in;
            default: ac_out = ac_in;
        endcase
    end

    always_comb begin
        if (op == OP_NEG)
            AST_NEG_SUM: assert (W'(ac_out + ac_in) == '0); // R3
        if (op == OP_CMP)
            AST_CMP_XOR: assert ((ac_out ^ ac_in) == '1); // R3
        if (op == OP_OSR)
            AST_OSR_KEEP: assert ((ac_out & ac_in) == ac_in); // R8
    end
endmodule

// File: rtl/opr_link_math.sv
module opr_link_math
    import opr_pkg::*;
(
    input  op_e  op,
    input  logic link_in,
    output logic link_out
);
    always_comb begin
        unique case (op)
            OP_LCLR: link_out = 1'b0;
            OP_LSET: link_out = 1'b1;
            OP_LCMP: link_out = ~link_in;
            default: link_out = link_in;
        endcase
    end
endmodule

// File: rtl/opr_ring.sv
module opr_ring #(
    parameter int W    = 12,
    parameter int DIST = 1,
    parameter bit LEFT = 1'b1
) (
    input  logic [W:0] ring_in,
    output logic [W:0] ring_out
);
    generate
        if (LEFT) begin : g_left
            assign ring_out = {ring_in[W-DIST:0], ring_in[W:W-DIST+1]};
        end else begin : g_right
            assign ring_out = {ring_in[DIST-1:0], ring_in[W:DIST]};
        end
    endgenerate
endmodule

// File: rtl/opr_acc_link.sv
module opr_acc_link
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0]    ac_cur,
    input  logic            link_cur,
    input  logic [W-1:0]    sw_val,
    input  logic [NREQ-1:0] op_req,
    input  logic            skip_req,
    input  logic            skip_cond,
    output logic [W-1:0]    ac_next,
    output logic            link_next,
    output logic            pc_inc
);
    localparam int NROT = 4;

    op_e          op;
    logic [W-1:0] math_ac;
    logic         math_link;
    logic [W:0]   ring_cur;
    logic [W:0]   rot_out [NROT];

    assign ring_cur = {link_cur, ac_cur};

    opr_pick u_pick (
        .req (op_req),
        .op  (op)
    );

    opr_acc_math #(.W(W)) u_acc (
        .op     (op),
        .ac_in  (ac_cur),
        .sw_in  (sw_val),
        .ac_out (math_ac)
    );

    opr_link_math u_link (
        .op       (op),
        .link_in  (link_cur),
        .link_out (math_link)
    );

    // index 0: left 1, 1: left 2, 2: right 1, 3: right 2
    generate
        for (genvar g = 0; g < NROT; g++) begin : g_rot
            opr_ring #(
                .W    (W),
                .DIST ((g % 2) + 1),
                .LEFT (g < 2)
            ) u_ring (
                .ring_in  (ring_cur),
                .ring_out (rot_out[g])
            );
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_RL1:  {link_next, ac_next} = rot_out[0];
            OP_RL2:  {link_next, ac_next} = rot_out[1];
            OP_RR1:  {link_next, ac_next} = rot_out[2];
            OP_RR2:  {link_next, ac_next} = rot_out[3];
            default: {link_next, ac_next} = {math_link, math_ac};
        endcase
    end

    assign pc_inc = skip_req & skip_cond;

    always_comb begin
        if (is_rotate(op))
            AST_ROT_WEIGHT: assert ($countones({link_next, ac_next}) == $countones(ring_cur)); // R5
        if (op == OP_INC || op == OP_NEG || op == OP_OSR || op == OP_CLR || op == OP_ONES)
            AST_LINK_HOLD: assert (link_next == link_cur); // R4
        if (op == OP_LCLR || op == OP_LSET || op == OP_LCMP)
            AST_AC_HOLD: assert (ac_next == ac_cur); // R7
        if (op_req == '0)
            AST_IDLE_PASS: assert (ac_next == ac_cur && link_next == link_cur); // R1
        if (pc_inc)
            AST_SKIP_GATE: assert (skip_req); // R9
    end
endmodule

// File: tb/tb_opr_acc_link.sv
module tb_opr_acc_link;
    localparam int W = 12;
    localparam int NREQ = 13;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [W-1:0]    ac_cur = '0;
    logic            link_cur = 1'b0;
    logic [W-1:0]    sw_val = '0;
    logic [NREQ-1:0] op_req = '0;
    logic            skip_req = 1'b0;
    logic            skip_cond = 1'b0;
    logic [W-1:0]    ac_next;
    logic            link_next;
    logic            pc_inc;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    opr_acc_link #(.W(W)) dut (
        .ac_cur    (ac_cur),
        .link_cur  (link_cur),
        .sw_val    (sw_val),
        .op_req    (op_req),
        .skip_req  (skip_req),
        .skip_cond (skip_cond),
        .ac_next   (ac_next),
        .link_next (link_next),
        .pc_inc    (pc_inc)
    );

    function automatic logic [W:0] model(input logic [NREQ-1:0] rq, input logic [W-1:0] a,
                                         input logic l, input logic [W-1:0] s);
        logic [W:0] r;
        int sel;
        r = {l, a};
        sel = -1;
        for (int i = NREQ - 1; i >= 0; i--) if (rq[i]) sel = i;
        case (sel)
            0:  r = {l, {W{1'b0}}};
            1:  r = {l, {W{1'b1}}};
            2:  r = {l, ~a};
            3:  r = {l, W'(~a + 1)};
            4:  r = {l, W'(a + 1)};
            5:  r = {r[W-1:0], r[W]};
            6:  r = {r[W-2:0], r[W:W-1]};
            7:  r = {r[0], r[W:1]};
            8:  r = {r[1:0], r[W:2]};
            9:  r = {1'b0, a};
            10: r = {1'b1, a};
            11: r = {~l, a};
            12: r = {l, a | s};
            default: r = {l, a};
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [NREQ-1:0] rq);
        int sel;
        sel = -1;
        for (int i = NREQ - 1; i >= 0; i--) if (rq[i]) sel = i;
        if ($countones(rq) > 1) return "R10";
        case (sel)
            -1: return "R1";
            0, 1: return "R2";
            2, 3: return "R3";
            4: return "R4";
            5, 6: return "R5";
            7, 8: return "R6";
            9, 10, 11: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply_check(input logic [NREQ-1:0] rq, input logic [W-1:0] a, input logic l,
                               input logic [W-1:0] s, input logic sr, input logic sc);
        logic [W:0] exp_v;
        @(posedge clk);
        op_req = rq; ac_cur = a; link_cur = l; sw_val = s; skip_req = sr; skip_cond = sc;
        @(negedge clk);
        exp_v = model(rq, a, l, s);
        checks++;
        if ({link_next, ac_next} !== exp_v) begin
            fails++;
            $display("FAIL %s req=%b actual=%o expected=%o", tag_of(rq), rq, {link_next, ac_next}, exp_v);
        end
        checks++;
        if (pc_inc !== (sr & sc)) begin
            fails++;
            $display("FAIL R9 actual=%b expected=%b", pc_inc, sr & sc);
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NREQ-1:0] rq;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 idle state after reset
        @(negedge clk);
        checks++;
        if (ac_next !== '0 || link_next !== 1'b0 || pc_inc !== 1'b0) begin
            fails++;
            $display("FAIL R1 actual=%o expected=0", {link_next, ac_next});
        end
        apply_check('0, 12'o5252, 1'b1, 12'o7777, 1'b0, 1'b1);          // R1
        apply_check(13'b1, 12'o1234, 1'b1, '0, 1'b0, 1'b0);             // R2 clear
        apply_check(13'b10, 12'o0001, 1'b0, '0, 1'b0, 1'b0);            // R2 ones
        apply_check(13'b100, 12'o1234, 1'b0, '0, 1'b0, 1'b0);           // R3 complement
        apply_check(13'b1000, 12'o0000, 1'b1, '0, 1'b0, 1'b0);          // R3 negate zero
        apply_check(13'b1000, 12'o4000, 1'b0, '0, 1'b0, 1'b0);          // R3 negate min
        apply_check(13'b10000, 12'o7777, 1'b0, '0, 1'b0, 1'b0);         // R4 wrap
        apply_check(13'b10000, 12'o7777, 1'b1, '0, 1'b0, 1'b0);         // R4 wrap, link held
        apply_check(13'b100000, 12'o4000, 1'b0, '0, 1'b0, 1'b0);        // R5 into link
        apply_check(13'b1000000, 12'o4000, 1'b1, '0, 1'b0, 1'b0);       // R5 two places
        apply_check(13'b10000000, 12'o0001, 1'b0, '0, 1'b0, 1'b0);      // R6 into link
        apply_check(13'b100000000, 12'o0001, 1'b0, '0, 1'b0, 1'b0);     // R6 two places
        apply_check(13'b100000000, 12'o0000, 1'b1, '0, 1'b0, 1'b0);     // R6 link to ac
        apply_check(13'b1000000000, 12'o3333, 1'b1, '0, 1'b0, 1'b0);    // R7 clear link
        apply_check(13'b10000000000, 12'o3333, 1'b0, '0, 1'b0, 1'b0);   // R7 set link
        apply_check(13'b100000000000, 12'o3333, 1'b1, '0, 1'b0, 1'b0);  // R7 invert link
        apply_check(13'b1000000000000, 12'o0707, 1'b1, 12'o1010, 1'b0, 1'b0); // R8
        apply_check(13'b0000000010100, 12'o0017, 1'b0, '0, 1'b1, 1'b1); // R10 complement beats inc
        apply_check(13'b1000000100000, 12'o4001, 1'b0, 12'o7777, 1'b1, 1'b0); // R10
        apply_check(13'b100000, 12'o0000, 1'b0, '0, 1'b1, 1'b0);        // R9 cond false
        apply_check(13'b10000, 12'o0000, 1'b0, '0, 1'b1, 1'b1);         // R9 asserted
        for (int n = 0; n < 400; n++) begin
            int pick;
            pick = int'($urandom_range(0, NREQ + 1));
            if (pick < NREQ) rq = NREQ'(1) << pick;
            else if (pick == NREQ) rq = '0;
            else rq = NREQ'($urandom);
            apply_check(rq, W'($urandom), 1'($urandom), W'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule